// File: doc/BRIEF.md
# UART Host Register Block

This block is the software-facing side of an asynchronous serial controller. A host processor reaches eight byte-wide registers through a 3-bit offset, separate read and write strobes and an 8-bit data bus. A bank-select bit in the line control register swaps the two lowest offsets between the data path (the receive and transmit bytes and the interrupt enables) and the 16-bit baud divisor. The serial shifters and the baud generator sit outside the block. They exchange whole bytes with it over simple valid/ready style ports and read its divisor, format and modem-control outputs.

After reset the block holds at most one byte in each direction. A write to the queue control offset can switch it to a mode in which each direction buffers up to a parameterised number of bytes (16 by default). The block merges four interrupt sources into one request line and a priority-coded identification byte.

Top module: `uart_host_regs`

## Requirements
- R1: After reset, the identification offset (2) reads 0x01, line status (5) reads 0x20, line control (3) reads 0x00, `irq_o` is low and `tx_valid_o` is low.
- R2: When line control bit 7 is set, offset 0 writes and reads the divisor low byte and offset 1 the high byte, both seen on `div_o`. The transmit path and the interrupt enable register are left untouched. `div_o` changes only through these writes.
- R3: Offsets 2 to 7 ignore line control bit 7. A write to offset 3 shows on `lcr_o` on the next cycle, and offset 7 is a scratch byte that reads back what was written.
- R4: In single-byte mode a received byte that arrives while a byte is held is dropped and sets overrun (line status bit 1). The held byte is kept.
- R5: Bit 0 of a write to offset 2 selects queue mode. In that mode each direction holds DEPTH bytes in arrival order. A receive byte beyond DEPTH is dropped and sets overrun. A transmit write beyond the capacity is dropped in either mode.
- R6: A read of offset 0 with bank bit clear returns the oldest received byte and removes it. Line status bit 0 (data ready) is set exactly while a received byte is held.
- R7: Line status bit 5 is set exactly while no transmit byte is held. `tx_data_o` presents held bytes in write order while `tx_valid_o` is high, and each byte leaves on a cycle with `tx_ready_i` high.
- R8: Bits 1 and 2 of a write to offset 2 empty the receive and transmit storage. A change of bit 0 empties both.
- R9: The identification byte has bit 0 low when an interrupt is pending, and bits 3:1 hold the winning source. The codes, from highest to lowest priority, are: 011 for line status (overrun or framing error), 010 for received data, 001 for transmit empty, 000 for modem change. Bits 7:6 read 11 in queue mode and 00 otherwise.
- R10: The enable bits at offset 1 are bit 0 received data, bit 1 transmit empty, bit 2 line status and bit 3 modem. `irq_o` is high exactly when an enabled source is pending.
- R11: A read of line status clears overrun and framing error (bit 3). A framing error is latched with a received byte flagged by `rx_ferr_i`. Modem status (6) reads the live `modem_i` in bits 7:4 and change flags in bits 3:0, and a read clears those flags.
- R12: The transmit-empty interrupt becomes pending when the transmit storage becomes empty, or when its enable bit is turned on while the storage is empty. It is cleared by a transmit write, or by a read of offset 2 that reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, side effects on the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from offset |
| irq_o | output | 1 | Interrupt request |
| lcr_o | output | 8 | Line control byte (frame format, bank bit) |
| div_o | output | 16 | Baud divisor |
| mcr_o | output | 5 | Modem control bits |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_ready_i | input | 1 | Shifter takes the byte |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_ferr_i | input | 1 | Framing error flag for this byte |
| modem_i | input | 4 | Modem input lines |

## Verification
The hardest situation to reach is the capacity boundary in queue mode while other sources compete for the identification byte. A seventeenth receive byte must be dropped and must raise the line status interrupt above the data interrupt that is already pending. The bench holds `tx_ready_i` low while it writes one byte past capacity, then drains the queue against a scoreboard. It then streams DEPTH+1 receive bytes with every enable on and reads the identification byte, line status and data back in turn. The flushes and the mode change are then applied with bytes held in both directions.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OFF_DATA = 3'd0,
    OFF_IER  = 3'd1,
    OFF_IIR  = 3'd2,
    OFF_LCR  = 3'd3,
    OFF_MCR  = 3'd4,
    OFF_LSR  = 3'd5,
    OFF_MSR  = 3'd6,
    OFF_SCR  = 3'd7
  } reg_off_e;

  localparam logic [2:0] ID_RLS  = 3'b011;
  localparam logic [2:0] ID_RDA  = 3'b010;
  localparam logic [2:0] ID_THRE = 3'b001;
  localparam logic [2:0] ID_MS   = 3'b000;
endpackage

// File: rtl/uart_byte_queue.sv
module uart_byte_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         single_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty_o = (cnt == '0);
  assign full_o  = single_i ? !empty_o : (cnt == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush_i) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_reg_pkg::*;
(
  input  logic [3:0] ier_i,
  input  logic       rls_i,
  input  logic       rda_i,
  input  logic       thre_i,
  input  logic       ms_i,
  input  logic       qmode_i,
  output logic [7:0] iir_o,
  output logic       irq_o
);
  logic [2:0] id;
  logic       pend;

  always_comb begin
    pend = 1'b1;
    id   = ID_MS;
    if (ier_i[2] && rls_i)       id = ID_RLS;
    else if (ier_i[0] && rda_i)  id = ID_RDA;
    else if (ier_i[1] && thre_i) id = ID_THRE;
    else if (ier_i[3] && ms_i)   id = ID_MS;
    else                         pend = 1'b0;
  end

  assign iir_o = {{2{qmode_i}}, 2'b00, pend ? id : 3'b000, !pend};
  assign irq_o = pend;
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_reg_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [BYTE_W-1:0] lcr_o,
  output logic [15:0]       div_o,
  output logic [4:0]        mcr_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  input  logic              rx_ferr_i,
  input  logic [3:0]        modem_i
);
  logic [3:0]        ier;
  logic [BYTE_W-1:0] lcr, scr, div_lo, div_hi;
  logic [4:0]        mcr;
  logic              qmode, ovr, ferr, thre_pend, tx_empty_q;
  logic [3:0]        ms_delta, ms_prev;
  logic              bank;
  logic [7:0]        iir, lsr, msr;

  logic rx_empty, rx_full, tx_empty, tx_full;
  logic [BYTE_W-1:0] rx_head;

  assign bank = lcr[7];

  // decoded strobes
  logic wr_thr, wr_ier, wr_dll, wr_dlm, wr_fcr;
  logic rd_rbr, rd_iir, rd_lsr, rd_msr;
  logic flush_rx, flush_tx, mode_chg;

  assign wr_thr = wr_i && addr_i == OFF_DATA && !bank;
  assign wr_dll = wr_i && addr_i == OFF_DATA &&  bank;
  assign wr_ier = wr_i && addr_i == OFF_IER  && !bank;
  assign wr_dlm = wr_i && addr_i == OFF_IER  &&  bank;
  assign wr_fcr = wr_i && addr_i == OFF_IIR;
  assign rd_rbr = rd_i && addr_i == OFF_DATA && !bank;
  assign rd_iir = rd_i && addr_i == OFF_IIR;
  assign rd_lsr = rd_i && addr_i == OFF_LSR;
  assign rd_msr = rd_i && addr_i == OFF_MSR;

  assign mode_chg = wr_fcr && (wdata_i[0] != qmode);
  assign flush_rx = wr_fcr && (wdata_i[1] || mode_chg);
  assign flush_tx = wr_fcr && (wdata_i[2] || mode_chg);

  uart_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk_i, .rst_ni,
    .flush_i (flush_rx),
    .single_i(!qmode),
    .push_i  (rx_valid_i),
    .din_i   (rx_data_i),
    .pop_i   (rd_rbr),
    .dout_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  uart_byte_queue #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
    .clk_i, .rst_ni,
    .flush_i (flush_tx),
    .single_i(!qmode),
    .push_i  (wr_thr),
    .din_i   (wdata_i),
    .pop_i   (tx_ready_i),
    .dout_o  (tx_data_o),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );

  assign tx_valid_o = !tx_empty;

  uart_irq_prio u_prio (
    .ier_i  (ier),
    .rls_i  (ovr || ferr),
    .rda_i  (!rx_empty),
    .thre_i (thre_pend),
    .ms_i   (|ms_delta),
    .qmode_i(qmode),
    .iir_o  (iir),
    .irq_o  (irq_o)
  );

  assign lsr = {2'b00, tx_empty, 1'b0, ferr, 1'b0, ovr, !rx_empty};
  assign msr = {modem_i, ms_delta};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ier        <= '0;
      lcr        <= '0;
      mcr        <= '0;
      scr        <= '0;
      div_lo     <= '0;
      div_hi     <= '0;
      qmode      <= 1'b0;
      ovr        <= 1'b0;
      ferr       <= 1'b0;
      ms_delta   <= '0;
      ms_prev    <= '0;
      thre_pend  <= 1'b0;
      tx_empty_q <= 1'b1;
    end else begin
      if (wr_ier) ier <= wdata_i[3:0];
      if (wr_dll) div_lo <= wdata_i;
      if (wr_dlm) div_hi <= wdata_i;
      if (wr_fcr) qmode <= wdata_i[0];
      if (wr_i && addr_i == OFF_LCR) lcr <= wdata_i;
      if (wr_i && addr_i == OFF_MCR) mcr <= wdata_i[4:0];
      if (wr_i && addr_i == OFF_SCR) scr <= wdata_i;

      // new events win over the clearing read
      ovr  <= (ovr  && !rd_lsr) || (rx_valid_i && rx_full && !flush_rx);
      ferr <= (ferr && !rd_lsr) || (rx_valid_i && !rx_full && rx_ferr_i && !flush_rx);

      ms_prev  <= modem_i;
      ms_delta <= (rd_msr ? 4'b0 : ms_delta) | (modem_i ^ ms_prev);

      tx_empty_q <= tx_empty;
      if (wr_thr)
        thre_pend <= 1'b0;
      else if (tx_empty && !tx_empty_q)
        thre_pend <= 1'b1;
      else if (wr_ier && wdata_i[1] && !ier[1] && tx_empty)
        thre_pend <= 1'b1;
      else if (rd_iir && iir[3:0] == {ID_THRE, 1'b0})
        thre_pend <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_DATA: rdata_o = bank ? div_lo : rx_head;
      OFF_IER:  rdata_o = bank ? div_hi : {4'b0, ier};
      OFF_IIR:  rdata_o = iir;
      OFF_LCR:  rdata_o = lcr;
      OFF_MCR:  rdata_o = {3'b0, mcr};
      OFF_LSR:  rdata_o = lsr;
      OFF_MSR:  rdata_o = msr;
      default:  rdata_o = scr;
    endcase
  end

  assign lcr_o = lcr;
  assign div_o = {div_hi, div_lo};
  assign mcr_o = mcr;
endmodule

// File: rtl/uart_host_regs_chk.sv
module uart_host_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [7:0]  rdata_o,
  input logic        irq_o,
  input logic [7:0]  lcr_o,
  input logic [15:0] div_o,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_ready_i
);
  a_r1_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd2 && !irq_o) |-> rdata_o[3:0] == 4'h1);

  a_r9_pend_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == 3'd2 && irq_o) |-> !rdata_o[0]);

  a_r2_div_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && lcr_o[7] && addr_i <= 3'd1) |=> $stable(div_o));

  a_r3_lcr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd3) |=> lcr_o == $past(wdata_i));

  a_r7_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !(wr_i && addr_i == 3'd2))
      |=> tx_valid_o && $stable(tx_data_o));

  a_r8_tx_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 3'd2 && wdata_i[2]) |=> !tx_valid_o);
endmodule

bind uart_host_regs uart_host_regs_chk u_chk (
  .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o,
  .lcr_o, .div_o, .tx_data_o, .tx_valid_o, .tx_ready_i
);

// File: tb/uart_host_regs_tb_top.sv
module uart_host_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o, lcr_o, tx_data_o;
  logic irq_o, tx_valid_o;
  logic [15:0] div_o;
  logic [4:0] mcr_o;
  logic tx_ready_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic rx_valid_i = 1'b0, rx_ferr_i = 1'b0;
  logic [3:0] modem_i = '0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_host_regs #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .irq_o,
    .lcr_o, .div_o, .mcr_o, .tx_data_o, .tx_valid_o, .tx_ready_i,
    .rx_data_i, .rx_valid_i, .rx_ferr_i, .modem_i
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk); #1;
    wr_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    addr_i = a; rd_i = 1'b1;
    @(negedge clk);
    d = rdata_o;
    @(posedge clk); #1;
    rd_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    reg_rd(a, v);
    check(req, {8'h0, v}, {8'h0, exp});
  endtask

  // driver: THR write, scoreboard expects it only when accepted
  task automatic thr_wr(input logic [7:0] d, input bit accept);
    if (accept) exp_q.push_back(d);
    reg_wr(3'd0, d);
  endtask

  task automatic rx_push(input logic [7:0] d, input logic fe);
    @(posedge clk); #1;
    rx_data_i = d; rx_ferr_i = fe; rx_valid_i = 1'b1;
    @(posedge clk); #1;
    rx_valid_i = 1'b0; rx_ferr_i = 1'b0;
  endtask

  task automatic drain();
    @(posedge clk); #1;
    tx_ready_i = 1'b1;
    repeat (DEPTH + 4) @(posedge clk);
    #1 tx_ready_i = 1'b0;
  endtask

  // monitor: each transmit handshake is compared against the scoreboard (R7)
  always @(negedge clk) begin
    if (rst_ni && tx_valid_o && tx_ready_i) begin
      if (exp_q.size() == 0) check("R7 unexpected tx byte", {8'h0, tx_data_o}, 16'hxxxx);
      else check("R7 tx order", {8'h0, tx_data_o}, {8'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'h0, irq_o}, 16'h0);
    check("R1 tx_valid", {15'h0, tx_valid_o}, 16'h0);
    rd_chk("R1 iir", 3'd2, 8'h01);
    rd_chk("R1 lsr", 3'd5, 8'h20);
    rd_chk("R1 lcr", 3'd3, 8'h00);

    // R2 divisor bank, R3 offsets above 1 unaffected by bank
    reg_wr(3'd3, 8'h83);
    reg_wr(3'd0, 8'h34);
    reg_wr(3'd1, 8'h12);
    @(negedge clk);
    check("R2 div_o", div_o, 16'h1234);
    check("R2 no tx", {15'h0, tx_valid_o}, 16'h0);
    rd_chk("R2 dll", 3'd0, 8'h34);
    rd_chk("R2 dlm", 3'd1, 8'h12);
    reg_wr(3'd7, 8'h5A);
    rd_chk("R3 lcr banked", 3'd3, 8'h83);
    reg_wr(3'd3, 8'h03);
    @(negedge clk);
    check("R3 lcr_o", {8'h0, lcr_o}, 16'h0003);
    rd_chk("R2 ier untouched", 3'd1, 8'h00);
    rd_chk("R3 scratch", 3'd7, 8'h5A);
    reg_wr(3'd4, 8'h1F);
    @(negedge clk);
    check("R3 mcr_o", {11'h0, mcr_o}, 16'h001F);

    // R4 single-byte overrun, R6 pop, R11 lsr clear
    rx_push(8'hA1, 1'b0);
    rx_push(8'hB2, 1'b0);
    rd_chk("R4 lsr overrun", 3'd5, 8'h23);
    rd_chk("R11 lsr cleared", 3'd5, 8'h21);
    rd_chk("R4 kept byte", 3'd0, 8'hA1);
    rd_chk("R6 data ready clear", 3'd5, 8'h20);

    // R7 single-byte transmit, second write dropped
    thr_wr(8'h11, 1'b1);
    thr_wr(8'h22, 1'b0);
    rd_chk("R7 lsr busy", 3'd5, 8'h00);
    drain();
    check("R7 tx all sent", exp_q.size(), 16'd0);
    rd_chk("R7 lsr empty", 3'd5, 8'h20);

    // R10/R12 enables and transmit-empty pending
    reg_wr(3'd1, 8'h0F);
    @(negedge clk);
    check("R10 irq thre", {15'h0, irq_o}, 16'h1);
    rd_chk("R12 iir thre", 3'd2, 8'h02);
    rd_chk("R12 iir cleared by read", 3'd2, 8'h01);
    check("R10 irq idle", {15'h0, irq_o}, 16'h0);

    // R9 priority: line status above data, R11 framing
    rx_push(8'h5C, 1'b1);
    rd_chk("R9 iir rls", 3'd2, 8'h06);
    rd_chk("R11 lsr framing", 3'd5, 8'h29);
    rd_chk("R9 iir rda", 3'd2, 8'h04);
    rd_chk("R6 rbr", 3'd0, 8'h5C);
    rd_chk("R9 iir none", 3'd2, 8'h01);

    // R11 modem change
    @(posedge clk); #1 modem_i = 4'b0001;
    @(posedge clk); @(negedge clk);
    check("R10 irq ms", {15'h0, irq_o}, 16'h1);
    rd_chk("R9 iir ms", 3'd2, 8'h00);
    rd_chk("R11 msr", 3'd6, 8'h11);
    rd_chk("R11 msr delta cleared", 3'd6, 8'h10);
    rd_chk("R9 iir after msr", 3'd2, 8'h01);

    // R5 queue mode transmit
    reg_wr(3'd2, 8'h01);
    rd_chk("R9 qmode iir", 3'd2, 8'hC1);
    for (int i = 0; i < DEPTH + 1; i++) thr_wr(8'h40 + 8'(i), i < DEPTH);
    rd_chk("R7 lsr tx full", 3'd5, 8'h00);
    drain();
    check("R5 tx queue drained", exp_q.size(), 16'd0);
    rd_chk("R12 iir thre qmode", 3'd2, 8'hC2);
    rd_chk("R12 iir clear qmode", 3'd2, 8'hC1);

    // R5 queue mode receive with overrun beyond DEPTH
    for (int i = 0; i < DEPTH + 1; i++) rx_push(8'h80 + 8'(i), 1'b0);
    rd_chk("R9 iir rls over rda", 3'd2, 8'hC6);
    rd_chk("R5 lsr overrun", 3'd5, 8'h23);
    rd_chk("R9 iir rda qmode", 3'd2, 8'hC4);
    for (int i = 0; i < DEPTH; i++) begin
      reg_rd(3'd0, rd_val);
      check("R5 rx order", {8'h0, rd_val}, {8'h0, 8'h80 + 8'(i)});
    end
    rd_chk("R6 lsr after drain", 3'd5, 8'h20);

    // R8 flushes
    rx_push(8'h01, 1'b0);
    rx_push(8'h02, 1'b0);
    reg_wr(3'd2, 8'h03);
    rd_chk("R8 rx flushed", 3'd5, 8'h20);
    thr_wr(8'h61, 1'b1);
    thr_wr(8'h62, 1'b1);
    reg_wr(3'd2, 8'h05);
    exp_q.delete();
    @(negedge clk);
    check("R8 tx flushed", {15'h0, tx_valid_o}, 16'h0);
    rd_chk("R8 lsr after tx flush", 3'd5, 8'h20);
    rd_chk("R12 thre after flush", 3'd2, 8'hC2);
    rx_push(8'h03, 1'b0);
    reg_wr(3'd2, 8'h00);
    rd_chk("R8 mode change flush", 3'd5, 8'h20);
    rd_chk("R9 back to single", 3'd2, 8'h01);

    finish_run();
  end
endmodule